// File: doc/BRIEF.md
# Doze CPU Clock-Enable Divider

This block slows the CPU while the peripherals keep running at full speed. It produces a CPU clock-enable pulse from the system clock. Peripherals stay on the undivided system clock, so both domains share one clock and remain synchronous. The CPU pulse appears once every 2^k system cycles, where k is a 3-bit ratio field. Software sets this up through a 16-bit control register with a write strobe and a combinational readback.

The register has three fields: a doze-enable flag, the ratio field, and a return-on-interrupt flag. While doze is off, the enable is high on every cycle. If return-on-interrupt is set, a pending interrupt clears the doze flag in hardware, and the CPU is back at full speed without any software action. A new ratio is held back until the current divider period ends, so a running period is never cut short or doubled.

Top module: `doze_clkdiv`

## Requirements
- R1: After reset the readback is 0x0000 and `cpu_ce` is high on every cycle.
- R2: A write stores wr_data bit 15 (return-on-interrupt), bits 14:12 (ratio k) and bit 11 (doze enable). These are visible on `rd_data` in the next cycle. All other readback bits are 0.
- R3: With bit 11 set and the ratio steady at k, consecutive `cpu_ce` pulses are exactly 2^k cycles apart (k=0 gives 1:1, k=7 gives 1:128).
- R4: In the first cycle after doze becomes enabled, `cpu_ce` is high.
- R5: Suppose bit 15 of the register value after any write in that cycle is 1 and `irq_pending` is high. Then bit 11 reads 0 from the next cycle, and `cpu_ce` is high every cycle from then on.
- R6: With bit 11 clear, `cpu_ce` is high on every cycle, whatever the ratio field holds.
- R7: With bit 15 clear, `irq_pending` has no effect on the register or on the `cpu_ce` pattern.
- R8: A ratio written during doze takes effect only after the current period ends. The next pulse still comes 2^k_old cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with peripherals |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| irq_pending | input | 1 | Any enabled interrupt pending |
| rd_data | output | 16 | Control register readback |
| cpu_ce | output | 1 | CPU clock-enable pulse |

## Verification
The bench builds the block with its default 3-bit ratio field. This makes all eight ratios reachable, up to the 128-cycle period. Directed runs measure the pulse spacing for each ratio. They also cover a ratio rewrite in the middle of a period and interrupts with return-on-interrupt both set and clear. Random writes and interrupts are then checked cycle by cycle against a bench reference model.

// File: rtl/doze_clkdiv.sv
module doze_clkdiv #(
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 3,
  parameter int EN_BIT  = 11,
  parameter int SEL_LSB = 12,
  parameter int ROI_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_pending,
  output logic [DATA_W-1:0] rd_data,
  output logic              cpu_ce
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic             roi_q, doze_q;
  logic [SEL_W-1:0] sel_q, act_q;
  logic [CNT_W-1:0] cnt_q, lim;

  logic             roi_d, doze_w, doze_d, wrap;
  logic [SEL_W-1:0] sel_d;
  logic             unused_wr_bits;

  assign roi_d  = wr_en ? wr_data[ROI_BIT] : roi_q;
  assign sel_d  = wr_en ? wr_data[SEL_LSB +: SEL_W] : sel_q;
  assign doze_w = wr_en ? wr_data[EN_BIT] : doze_q;
  assign doze_d = doze_w & ~(roi_d & irq_pending);

  assign lim  = CNT_W'((64'd1 << act_q) - 64'd1);
  assign wrap = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      roi_q  <= 1'b0;
      doze_q <= 1'b0;
      sel_q  <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
    end else begin
      roi_q  <= roi_d;
      doze_q <= doze_d;
      sel_q  <= sel_d;
      if (!doze_q || wrap) begin
        cnt_q <= '0;
        act_q <= sel_d;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cpu_ce = !doze_q || (cnt_q == '0);

  always_comb begin
    rd_data                      = '0;
    rd_data[ROI_BIT]             = roi_q;
    rd_data[SEL_LSB +: SEL_W]    = sel_q;
    rd_data[EN_BIT]              = doze_q;
  end

  assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/doze_clkdiv_chk.sv
module doze_clkdiv_chk #(
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 3,
  parameter int EN_BIT  = 11,
  parameter int SEL_LSB = 12,
  parameter int ROI_BIT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_pending,
  input logic [DATA_W-1:0] rd_data,
  input logic              cpu_ce
);
  localparam int MAXGAP = (1 << (1 << SEL_W) - 1) - 1;
  localparam logic [DATA_W-1:0] KEEP =
    DATA_W'((64'd1 << ROI_BIT) | (64'd1 << EN_BIT) |
            (((64'd1 << SEL_W) - 64'd1) << SEL_LSB));

  logic doze, roi;
  logic [31:0] gap;
  assign doze = rd_data[EN_BIT];
  assign roi  = rd_data[ROI_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= 0;
    else if (cpu_ce || !doze) gap <= 0;
    else gap <= gap + 1;
  end

  assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !doze |-> cpu_ce);

  assert_roi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (doze && roi && irq_pending && !wr_en) |=> !rd_data[EN_BIT]);

  assert_irq_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (doze && !roi && irq_pending && !wr_en) |=> rd_data[EN_BIT]);

  assert_max_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= MAXGAP);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(irq_pending && wr_data[ROI_BIT])) |=> rd_data == $past(wr_data & KEEP));
endmodule

bind doze_clkdiv doze_clkdiv_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .EN_BIT(EN_BIT), .SEL_LSB(SEL_LSB), .ROI_BIT(ROI_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .irq_pending(irq_pending), .rd_data(rd_data), .cpu_ce(cpu_ce)
);

// File: tb/doze_clkdiv_tb_top.sv
`timescale 1ns/1ps
module doze_clkdiv_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq_pending = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic cpu_ce;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m_reg;
  int m_cnt, m_sel;
  logic last_ce;
  logic [15:0] last_rd;

  doze_clkdiv dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                     .irq_pending(irq_pending), .rd_data(rd_data), .cpu_ce(cpu_ce));

  always #5 clk = ~clk;

  function automatic logic [15:0] keep(input logic [15:0] d);
    return d & 16'hF800;
  endfunction

  function automatic logic exp_ce();
    return !m_reg[11] || (m_cnt == 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [15:0] d, input bit irq);
    logic [15:0] nd;
    nd = w ? keep(d) : m_reg;
    if (nd[15] && irq) nd[11] = 1'b0;
    if (!m_reg[11] || m_cnt == (1 << m_sel) - 1) begin
      m_cnt = 0;
      m_sel = int'(nd[14:12]);
    end else m_cnt++;
    m_reg = nd;
  endtask

  task automatic cyc(input bit w, input logic [15:0] d, input bit irq);
    @(negedge clk);
    last_ce = cpu_ce;
    last_rd = rd_data;
    chk(rd_data == m_reg, "R2 readback", rd_data, m_reg);
    chk(cpu_ce == exp_ce(), "R3 cpu_ce model", cpu_ce, exp_ce());
    wr_en = w; wr_data = d; irq_pending = irq;
    @(posedge clk); #1;
    step(w, d, irq);
    wr_en = 1'b0; irq_pending = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int first, second, idx;
    void'($urandom(32'h5EED1234));
    m_reg = '0; m_cnt = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(rd_data == 16'h0000, "R1 reset readback", rd_data, 0);
    chk(cpu_ce == 1'b1, "R1 reset cpu_ce", cpu_ce, 1);

    // R2 unused bits read zero
    cyc(1, 16'hFFFF & ~16'h0800, 0);
    cyc(0, 0, 0);
    chk(last_rd == 16'hF000, "R2 masked bits", last_rd, 16'hF000);

    // R6 doze off with ratio 7
    cyc(1, 16'h7000, 0);
    for (int i = 0; i < 20; i++) begin
      cyc(0, 0, 0);
      chk(last_ce == 1'b1, "R6 full rate", last_ce, 1);
    end

    // R3 / R4 spacing for each ratio
    for (int k = 0; k < 8; k++) begin
      cyc(1, 16'h0000, 0);
      cyc(0, 0, 0);
      cyc(1, 16'(k << 12) | 16'h0800, 0);
      first = -1; second = -1; idx = 0;
      while (second < 0 && idx < 400) begin
        cyc(0, 0, 0);
        if (idx == 0) chk(last_ce == 1'b1, "R4 first pulse", last_ce, 1);
        if (last_ce) begin
          if (first < 0) first = idx; else second = idx;
        end
        idx++;
      end
      chk(second - first == (1 << k), "R3 pulse spacing", second - first, 1 << k);
    end

    // R8 ratio change mid-period
    cyc(1, 16'h0000, 0);
    cyc(1, 16'h3800, 0);
    for (int i = 0; i < 2; i++) cyc(0, 0, 0);
    cyc(1, 16'h0800, 0);
    for (int i = 3; i < 10; i++) begin
      cyc(0, 0, 0);
      chk(last_ce == (i >= 8), "R8 period kept", last_ce, i >= 8);
    end

    // R7 irq ignored without return-on-interrupt
    cyc(1, 16'h5800, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1);
    cyc(0, 0, 0);
    chk(last_rd == 16'h5800, "R7 doze kept", last_rd, 16'h5800);

    // R5 auto return to full speed
    cyc(1, 16'hD800, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    cyc(0, 0, 1);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0);
      chk(last_rd[11] == 1'b0 && last_ce == 1'b1, "R5 return on irq",
          {last_rd[11], last_ce}, 2'b01);
    end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 30) == 0, 16'($urandom), ($urandom % 8) == 0);
    end

    finish_run();
  end
endmodule